// File: doc/BRIEF.md
# Arithmetic and Logic Unit with Condition Flags

This block is the combinational datapath of a small accumulator machine. It takes two operands, a function code, a width select and the current condition-code nibble, and in the same cycle returns the function's value, a write-enable telling the surrounding register logic whether that value should be stored, and the next condition-code nibble (negative, zero, overflow, carry).

The width select picks 16-bit operation or 8-bit operation on the low byte. Each function has its own flag policy. Arithmetic functions update all four flags. Bitwise functions clear overflow and keep the incoming carry. Complement forces carry high. Clear forces a fixed pattern. The comparison functions only produce flags. The caller keeps the flag register and feeds it back through `ccr_i`.

Top module: `alu_flags_core`

## Requirements
- R1: Function codes on `func_i` are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 negate, 5 AND, 6 OR, 7 XOR, 8 complement, 9 clear, 10 bit set, 11 bit clear, 12 compare, 13 test, 14 bit test. Code 15 is reserved: it passes `ccr_i` to `ccr_o` unchanged, drives a zero value and holds `wr_o` low. Flag nibbles are ordered N,Z,V,C from bit 3 down to bit 0.
- R2: For every code except 15, N equals the top bit of the value for the active width: bit 15 when `wide_i`=1, bit 7 when `wide_i`=0.
- R3: For every code except 15, Z is 1 exactly when the value at the active width is zero.
- R4: Add returns a+b. Add-with-carry also adds the incoming C. C is the unsigned carry out of the active width. V is set when both operands share a sign and the sum's sign differs.
- R5: Subtract returns a-b. Subtract-with-borrow also subtracts the incoming C. C is set when a borrow occurs. V is the signed overflow of the subtraction.
- R6: Negate returns 0-a. V is set only for the most negative value, and C is set whenever the result is non-zero.
- R7: AND, OR and XOR update N and Z from the result, clear V, and keep C from `ccr_i`.
- R8: Complement returns the bitwise inverse of a, clears V and sets C.
- R9: Clear returns zero with flags N=0, Z=1, V=0, C=0, whatever `ccr_i` holds.
- R10: Bit set returns a OR b, and bit clear returns a AND NOT b, with b as the mask. Both clear V and keep C.
- R11: Compare sets all four flags as subtract does, and holds `wr_o` low.
- R12: Bit test sets N and Z from a AND b, clears V, keeps C and holds `wr_o` low.
- R13: Test sets N and Z from a (a minus zero) and clears both V and C.
- R14: When `wide_i`=0, bits 15:8 of both operands have no effect, and bits 15:8 of `res_o` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a_i | input | 16 | First operand (accumulator side) |
| op_b_i | input | 16 | Second operand or bit mask |
| func_i | input | 4 | Function code |
| wide_i | input | 1 | 1 = 16-bit operation, 0 = 8-bit on low byte |
| ccr_i | input | 4 | Current flags N,Z,V,C |
| res_o | output | 16 | Function value |
| wr_o | output | 1 | Value should be written back |
| ccr_o | output | 4 | Next flags N,Z,V,C |

## Verification
The bound checker evaluates, on every input change, the rules that hold whatever the operand values are. These rules are: N and Z agree with the value at the active width, the upper byte stays zero in narrow mode, the bitwise group keeps carry and clears overflow, clear yields its fixed pattern, complement and test force their carry values, and the flag-only functions never assert write. Arithmetic correctness cannot be judged without a reference result, so only the bench's directed scenarios can show it. These scenarios cover carry and borrow at both widths, signed overflow in each direction, the carry and borrow input of the chained forms, and negation of zero and of the most negative value.

// File: rtl/alu_flags_pkg.sv
// Shared function codes and the flag nibble layout for the ALU.
package alu_flags_pkg;

    typedef enum logic [3:0] {
        FN_ADD  = 4'd0,
        FN_ADC  = 4'd1,
        FN_SUB  = 4'd2,
        FN_SBC  = 4'd3,
        FN_NEG  = 4'd4,
        FN_AND  = 4'd5,
        FN_OR   = 4'd6,
        FN_XOR  = 4'd7,
        FN_COM  = 4'd8,
        FN_CLR  = 4'd9,
        FN_BSET = 4'd10,
        FN_BCLR = 4'd11,
        FN_CMP  = 4'd12,
        FN_TST  = 4'd13,
        FN_BIT  = 4'd14,
        FN_RSV  = 4'd15
    } alu_fn_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

endpackage

// File: rtl/alu_addsub.sv
// Adder with a runtime width select.
// Computes x + y + cin at full width W or on the low W/2 bits.
// Subtraction is formed by the caller (inverted y, adjusted cin).
// Assumes W is even. In narrow mode the sum's upper half is zero.
module alu_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         cin_i,
    input  logic         wide_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);
    localparam int H   = W / 2;
    localparam int WP1 = W + 1;
    localparam int HP1 = H + 1;

    logic [W:0] full_sum;
    logic [H:0] half_sum;
    logic       xm, ym, sm;

    // Form both width sums and choose the active one with its sign bits.
    always_comb begin
        full_sum = {1'b0, x_i} + {1'b0, y_i} + WP1'(cin_i);
        half_sum = {1'b0, x_i[H-1:0]} + {1'b0, y_i[H-1:0]} + HP1'(cin_i);
        if (wide_i) begin
            sum_o  = full_sum[W-1:0];
            cout_o = full_sum[W];
            xm     = x_i[W-1];
            ym     = y_i[W-1];
            sm     = full_sum[W-1];
        end else begin
            sum_o  = {{(W-H){1'b0}}, half_sum[H-1:0]};
            cout_o = half_sum[H];
            xm     = x_i[H-1];
            ym     = y_i[H-1];
            sm     = half_sum[H-1];
        end
        ovf_o = (xm & ym & ~sm) | (~xm & ~ym & sm);
    end

endmodule

// File: rtl/alu_bitwise.sv
// Bitwise unit: AND, OR, XOR, complement, mask set/clear, bit test.
// Any other code passes operand a through (used by test).
// Assumes the caller trims the value to the active width.
module alu_bitwise #(
    parameter int W = 16
) (
    input  alu_flags_pkg::alu_fn_e func_i,
    input  logic [W-1:0]           a_i,
    input  logic [W-1:0]           b_i,
    output logic [W-1:0]           y_o
);
    import alu_flags_pkg::*;

    // Select the bitwise combination for the function code.
    always_comb begin
        unique case (func_i)
            FN_AND, FN_BIT: y_o = a_i & b_i;
            FN_OR,  FN_BSET: y_o = a_i | b_i;
            FN_XOR:          y_o = a_i ^ b_i;
            FN_COM:          y_o = ~a_i;
            FN_BCLR:         y_o = a_i & ~b_i;
            default:         y_o = a_i;
        endcase
    end

endmodule

// File: rtl/alu_nz_eval.sv
// Trims a value to the active width and derives its sign and zero flags.
// Assumes W is even. In narrow mode the upper half is cleared.
module alu_nz_eval #(
    parameter int W = 16
) (
    input  logic [W-1:0] val_i,
    input  logic         wide_i,
    output logic [W-1:0] trim_o,
    output logic         neg_o,
    output logic         zero_o
);
    localparam int H = W / 2;

    // Clear the unused half and read sign and zero at the active width.
    always_comb begin
        trim_o = wide_i ? val_i : {{(W-H){1'b0}}, val_i[H-1:0]};
        neg_o  = wide_i ? val_i[W-1] : val_i[H-1];
        zero_o = (trim_o == '0);
    end

endmodule

// File: rtl/alu_flags_core.sv
// Combinational ALU with per-function condition flag policy.
// Routes operands to the adder or the bitwise unit, picks the value,
// and builds the next N,Z,V,C nibble from the function's flag rule.
// Assumes the caller holds the flag register and feeds it back on ccr_i.
module alu_flags_core #(
    parameter int W = 16
) (
    input  logic [W-1:0] op_a_i,
    input  logic [W-1:0] op_b_i,
    input  logic [3:0]   func_i,
    input  logic         wide_i,
    input  logic [3:0]   ccr_i,
    output logic [W-1:0] res_o,
    output logic         wr_o,
    output logic [3:0]   ccr_o
);
    import alu_flags_pkg::*;

    alu_fn_e      fn;
    ccr_t         cin_f;
    ccr_t         cout_f;
    logic [W-1:0] add_x, add_y, add_sum;
    logic         add_cin, add_cout, add_ovf;
    logic [W-1:0] bw_val;
    logic [W-1:0] raw_val, trim_val;
    logic         val_neg, val_zero;
    logic         is_arith, is_sub_like;

    assign fn    = alu_fn_e'(func_i);
    assign cin_f = ccr_t'(ccr_i);

    // Classify the code into arithmetic and borrow-style groups.
    always_comb begin
        is_arith    = (fn inside {FN_ADD, FN_ADC, FN_SUB, FN_SBC, FN_NEG, FN_CMP});
        is_sub_like = (fn inside {FN_SUB, FN_SBC, FN_NEG, FN_CMP});
    end

    // Prepare adder operands: subtraction adds the inverted subtrahend.
    always_comb begin
        add_x   = op_a_i;
        add_y   = op_b_i;
        add_cin = 1'b0;
        unique case (fn)
            FN_ADC:         add_cin = cin_f.c;
            FN_SUB, FN_CMP: begin add_y = ~op_b_i; add_cin = 1'b1; end
            FN_SBC:         begin add_y = ~op_b_i; add_cin = ~cin_f.c; end
            FN_NEG:         begin add_x = '0; add_y = ~op_a_i; add_cin = 1'b1; end
            default: ;
        endcase
    end

    alu_addsub #(.W(W)) u_addsub (
        .x_i    (add_x),
        .y_i    (add_y),
        .cin_i  (add_cin),
        .wide_i (wide_i),
        .sum_o  (add_sum),
        .cout_o (add_cout),
        .ovf_o  (add_ovf)
    );

    alu_bitwise #(.W(W)) u_bitwise (
        .func_i (fn),
        .a_i    (op_a_i),
        .b_i    (op_b_i),
        .y_o    (bw_val)
    );

    // Choose the untrimmed value for the function.
    always_comb begin
        if (is_arith)                    raw_val = add_sum;
        else if (fn inside {FN_CLR, FN_RSV}) raw_val = '0;
        else                             raw_val = bw_val;
    end

    alu_nz_eval #(.W(W)) u_nz (
        .val_i  (raw_val),
        .wide_i (wide_i),
        .trim_o (trim_val),
        .neg_o  (val_neg),
        .zero_o (val_zero)
    );

    // Apply the per-function flag rule and the write-back decision.
    always_comb begin
        cout_f   = '{n: val_neg, z: val_zero, v: 1'b0, c: cin_f.c};
        wr_o     = 1'b1;
        unique case (fn)
            FN_ADD, FN_ADC: begin
                cout_f.v = add_ovf;
                cout_f.c = add_cout;
            end
            FN_SUB, FN_SBC: begin
                cout_f.v = add_ovf;
                cout_f.c = ~add_cout;
            end
            FN_CMP: begin
                cout_f.v = add_ovf;
                cout_f.c = ~add_cout;
                wr_o     = 1'b0;
            end
            FN_NEG: begin
                cout_f.v = add_ovf;
                cout_f.c = ~val_zero;
            end
            FN_COM: cout_f.c = 1'b1;
            FN_TST: cout_f.c = 1'b0;
            FN_CLR: cout_f   = '{n: 1'b0, z: 1'b1, v: 1'b0, c: 1'b0};
            FN_BIT: wr_o     = 1'b0;
            FN_RSV: begin
                cout_f = cin_f;
                wr_o   = 1'b0;
            end
            default: ;
        endcase
    end

    assign res_o = trim_val;
    assign ccr_o = cout_f;

endmodule

// File: rtl/alu_flags_core_chk.sv
// Property checker for alu_flags_core, attached by bind.
// Checks input-independent flag rules whenever any port changes.
// Assumes W is even.
module alu_flags_core_chk #(
    parameter int W = 16
) (
    input logic [W-1:0] op_a_i,
    input logic [W-1:0] op_b_i,
    input logic [3:0]   func_i,
    input logic         wide_i,
    input logic [3:0]   ccr_i,
    input logic [W-1:0] res_o,
    input logic         wr_o,
    input logic [3:0]   ccr_o
);
    import alu_flags_pkg::*;
    localparam int H = W / 2;

    logic not_rsv;
    logic bw_group;
    assign not_rsv  = (func_i != FN_RSV);
    assign bw_group = (func_i inside {FN_AND, FN_OR, FN_XOR, FN_BSET, FN_BCLR, FN_BIT});

    // Check the output rules against the ports on every change.
    always_comb begin
        if (not_rsv) begin
            assert_sign_flag_R2: assert (ccr_o[3] == (wide_i ? res_o[W-1] : res_o[H-1]));
            assert_zero_flag_R3: assert (ccr_o[2] == (res_o == '0));
        end else begin
            assert_reserved_hold_R1: assert (ccr_o == ccr_i && !wr_o && res_o == '0);
        end
        if (bw_group) begin
            assert_bitwise_keep_c_R7: assert (ccr_o[1] == 1'b0 && ccr_o[0] == ccr_i[0]);
        end
        if (func_i == FN_COM) begin
            assert_com_sets_c_R8: assert (ccr_o[1:0] == 2'b01);
        end
        if (func_i == FN_CLR) begin
            assert_clear_pattern_R9: assert (res_o == '0 && ccr_o == 4'b0100);
        end
        if (func_i == FN_CMP) begin
            assert_cmp_no_write_R11: assert (!wr_o);
        end
        if (func_i == FN_BIT) begin
            assert_bit_no_write_R12: assert (!wr_o);
        end
        if (func_i == FN_TST) begin
            assert_tst_clears_vc_R13: assert (ccr_o[1:0] == 2'b00);
        end
        if (!wide_i) begin
            assert_narrow_upper_zero_R14: assert (res_o[W-1:H] == '0);
        end
    end

endmodule

bind alu_flags_core alu_flags_core_chk #(.W(W)) u_chk (
    .op_a_i (op_a_i),
    .op_b_i (op_b_i),
    .func_i (func_i),
    .wide_i (wide_i),
    .ccr_i  (ccr_i),
    .res_o  (res_o),
    .wr_o   (wr_o),
    .ccr_o  (ccr_o)
);

// File: tb/alu_flags_core_test.sv
// Directed bench for alu_flags_core: one task per scenario.
module alu_flags_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a = '0, b = '0;
    logic [3:0]  fn = 4'd0;
    logic        wide = 1'b0;
    logic [3:0]  fin = 4'd0;
    logic [15:0] res;
    logic        wr;
    logic [3:0]  fout;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    alu_flags_core #(.W(16)) uut (
        .op_a_i (a),
        .op_b_i (b),
        .func_i (fn),
        .wide_i (wide),
        .ccr_i  (fin),
        .res_o  (res),
        .wr_o   (wr),
        .ccr_o  (fout)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive one operation at a rising edge, sample at the next falling edge.
    task automatic drive(input logic [3:0] f, input logic [15:0] x, input logic [15:0] y,
                         input logic w, input logic [3:0] c);
        @(posedge clk);
        fn = f; a = x; b = y; wide = w; fin = c;
        @(negedge clk);
    endtask

    task automatic expect_op(input string tag, input logic [15:0] er, input logic [3:0] ef,
                             input logic ew);
        check({tag, " value"}, res, er);
        check({tag, " flags"}, {12'd0, fout}, {12'd0, ef});
        check({tag, " write"}, {15'd0, wr}, {15'd0, ew});
    endtask

    task automatic t_reset_state;
        @(negedge clk);
        expect_op("R1 R3 idle add of zeros", 16'h0000, 4'b0100, 1'b1);
    endtask

    task automatic t_add;
        drive(4'd0, 16'h007F, 16'h0001, 1'b0, 4'b0000);
        expect_op("R4 R2 add signed overflow", 16'h0080, 4'b1010, 1'b1);
        drive(4'd0, 16'h00FF, 16'h0001, 1'b0, 4'b0000);
        expect_op("R4 R3 add carry to zero", 16'h0000, 4'b0101, 1'b1);
        drive(4'd0, 16'h8000, 16'h8000, 1'b1, 4'b0000);
        expect_op("R4 wide carry and overflow", 16'h0000, 4'b0111, 1'b1);
        drive(4'd1, 16'h0010, 16'h0020, 1'b0, 4'b0001);
        expect_op("R4 add with carry in", 16'h0031, 4'b0000, 1'b1);
    endtask

    task automatic t_sub;
        drive(4'd2, 16'h0005, 16'h0007, 1'b0, 4'b0000);
        expect_op("R5 sub borrow", 16'h00FE, 4'b1001, 1'b1);
        drive(4'd2, 16'h0080, 16'h0001, 1'b0, 4'b0000);
        expect_op("R5 sub signed overflow", 16'h007F, 4'b0010, 1'b1);
        drive(4'd3, 16'h1000, 16'h0001, 1'b1, 4'b0001);
        expect_op("R5 wide sub with borrow in", 16'h0FFE, 4'b0000, 1'b1);
    endtask

    task automatic t_neg;
        drive(4'd4, 16'h0080, 16'h0000, 1'b0, 4'b0000);
        expect_op("R6 negate most negative", 16'h0080, 4'b1011, 1'b1);
        drive(4'd4, 16'h0000, 16'h0000, 1'b0, 4'b0001);
        expect_op("R6 negate zero", 16'h0000, 4'b0100, 1'b1);
        drive(4'd4, 16'h0001, 16'h0000, 1'b0, 4'b0000);
        expect_op("R6 negate one", 16'h00FF, 4'b1001, 1'b1);
        drive(4'd4, 16'h8000, 16'h0000, 1'b1, 4'b0000);
        expect_op("R6 R2 wide negate most negative", 16'h8000, 4'b1011, 1'b1);
    endtask

    task automatic t_logic;
        drive(4'd5, 16'h00F0, 16'h003C, 1'b0, 4'b0011);
        expect_op("R7 and keeps carry", 16'h0030, 4'b0001, 1'b1);
        drive(4'd6, 16'h0080, 16'h0001, 1'b0, 4'b0000);
        expect_op("R7 or", 16'h0081, 4'b1000, 1'b1);
        drive(4'd7, 16'h00AA, 16'h00AA, 1'b0, 4'b0001);
        expect_op("R7 xor to zero", 16'h0000, 4'b0101, 1'b1);
        drive(4'd8, 16'h00FF, 16'h0000, 1'b1, 4'b0010);
        expect_op("R8 complement", 16'hFF00, 4'b1001, 1'b1);
    endtask

    task automatic t_clear_and_masks;
        drive(4'd9, 16'h0055, 16'h0000, 1'b0, 4'b1011);
        expect_op("R9 clear", 16'h0000, 4'b0100, 1'b1);
        drive(4'd10, 16'h0001, 16'h0080, 1'b0, 4'b0001);
        expect_op("R10 bit set", 16'h0081, 4'b1001, 1'b1);
        drive(4'd11, 16'h00FF, 16'h000F, 1'b0, 4'b0010);
        expect_op("R10 bit clear", 16'h00F0, 4'b1000, 1'b1);
    endtask

    task automatic t_tests;
        drive(4'd12, 16'h0030, 16'h0030, 1'b0, 4'b1001);
        check("R11 compare equal flags", {12'd0, fout}, 16'h0004);
        check("R11 compare equal write", {15'd0, wr}, 16'h0000);
        drive(4'd12, 16'h0010, 16'h0020, 1'b0, 4'b0000);
        check("R11 compare lower flags", {12'd0, fout}, 16'h0009);
        check("R11 compare lower write", {15'd0, wr}, 16'h0000);
        drive(4'd14, 16'h000F, 16'h00F0, 1'b0, 4'b0001);
        check("R12 bit test flags", {12'd0, fout}, 16'h0005);
        check("R12 bit test write", {15'd0, wr}, 16'h0000);
        drive(4'd13, 16'h0080, 16'h0000, 1'b0, 4'b0011);
        expect_op("R13 test negative", 16'h0080, 4'b1000, 1'b1);
        drive(4'd13, 16'h0000, 16'h0000, 1'b0, 4'b0011);
        expect_op("R13 test zero", 16'h0000, 4'b0100, 1'b1);
    endtask

    task automatic t_narrow_and_reserved;
        drive(4'd0, 16'h12FF, 16'h3401, 1'b0, 4'b0000);
        expect_op("R14 narrow ignores upper bytes", 16'h0000, 4'b0101, 1'b1);
        drive(4'd6, 16'hAB00, 16'hCD00, 1'b0, 4'b0000);
        expect_op("R14 narrow or of upper bytes only", 16'h0000, 4'b0100, 1'b1);
        drive(4'd15, 16'h1234, 16'h5678, 1'b1, 4'b1010);
        expect_op("R1 reserved code holds flags", 16'h0000, 4'b1010, 1'b0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_add();
        t_sub();
        t_neg();
        t_logic();
        t_clear_and_masks();
        t_tests();
        t_narrow_and_reserved();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule